// File: doc/BRIEF.md
# Lane-Wise Vector Byte Right Shifter

This datapath unit moves the bytes of a 256-bit vector toward the least significant end by a whole number of byte positions and writes zeros into the byte positions that are left empty at the top. The vector is split into two 128-bit lanes. Bytes never pass from one lane into the other. An 8-bit count gives the distance in bytes. Any count of 16 or more clears every lane that is shifted.

A 2-bit operating mode decides where the shifted data comes from and what happens to the upper lane. The unit also takes a length bit, and it reports an undefined-instruction condition for operand combinations that are not allowed. In that case the old destination value passes through unchanged and no write is requested. The unit has a single register stage, so a request accepted on one clock edge produces its result, write-enable and fault flag together one cycle later.

Top module: `lane_byte_rshift`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld_o`, `wr_en_o` and `undef_o` are 0 after that edge.
- R2: A request with `in_vld_i` high at an edge sets `out_vld_o` after that edge. A cycle with `in_vld_i` low gives `out_vld_o`, `wr_en_o` and `undef_o` all 0 after the following edge.
- R3: For a count `c` from 0 to 15, result byte `k` of a shifted lane (byte `k` = bits 8k+7:8k of the lane) is input byte `k+c` of the same lane when `k+c` is 15 or less, and 0 otherwise.
- R4: A count from 16 to 255 (any of `cnt_i[7:4]` set) makes every shifted lane all zeros.
- R5: Mode 2'b00 (in-place 128): the low lane of the result is the low lane of `dst_i` shifted, and bits 255:128 equal `dst_i[255:128]`. `src_i` and `len_i` have no effect.
- R6: Mode 2'b01 with `len_i` = 0 (narrow 128): the low lane of the result is the low lane of `src_i` shifted, and bits 255:128 are 0.
- R7: Mode 2'b10 (full 256): each 128-bit lane of `src_i` is shifted on its own by the same count, and `len_i` has no effect.
- R8: Mode 2'b01 with `len_i` = 1 raises `undef_o`.
- R9: Mode 2'b11 is reserved and raises `undef_o` whatever the value of `len_i`.
- R10: When `undef_o` is raised, `res_o` equals `dst_i` as it was when the request was accepted and `wr_en_o` is 0. For every other accepted request `wr_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Request valid |
| mode_i | input | 2 | Operating mode: 00 in-place 128, 01 narrow 128, 10 full 256, 11 reserved |
| len_i | input | 1 | Vector length bit; must be 0 in mode 01 |
| cnt_i | input | 8 | Shift distance in bytes |
| src_i | input | 256 | Source vector |
| dst_i | input | 256 | Old destination value |
| out_vld_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Destination write request |
| undef_o | output | 1 | Undefined-instruction flag |
| res_o | output | 256 | Result vector |

## Verification
The assertions treat `mode_i`, `cnt_i` and `dst_i` as meaningful only in the cycle that `in_vld_i` is high. They also assume that `rst_n` is released before the first request, so every `$past` value they compare against comes from a captured cycle. The stimulus follows both rules. It holds reset for several cycles and then drives a new complete request in each cycle of the sweep. That sweep covers every count, every mode encoding and both length values, over three data patterns. A single idle cycle is placed before the sweep starts.

// File: rtl/lbs_pkg.sv
// Package: shared types for the lane byte right shifter.
// Assumes: mode encoding is fixed by the requirements (00/01/10/11).
package lbs_pkg;
    typedef enum logic [1:0] {
        MODE_INPLACE = 2'b00,
        MODE_NARROW  = 2'b01,
        MODE_FULL    = 2'b10,
        MODE_RSVD    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        HI_KEEP  = 2'b00,
        HI_ZERO  = 2'b01,
        HI_SHIFT = 2'b10
    } hi_act_e;
endpackage

// File: rtl/lbs_lane_shift.sv
// Module: lbs_lane_shift
// Shifts one lane right by a byte count and fills the top with zeros.
// A count of LANE_BYTES or more clears the lane.
// Assumes: LANE_BYTES is a power of two and CNT_W is wider than log2(LANE_BYTES).
module lbs_lane_shift #(
    parameter int LANE_BYTES = 16,
    parameter int CNT_W      = 8
) (
    input  logic [LANE_BYTES*8-1:0] lane_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic [LANE_BYTES*8-1:0] lane_o
);
    localparam int IDX_W = $clog2(LANE_BYTES);

    logic             sat;
    logic [IDX_W-1:0] idx;

    assign sat = |cnt_i[CNT_W-1:IDX_W];
    assign idx = cnt_i[IDX_W-1:0];

    for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
        logic [IDX_W:0] sel;
        assign sel = {1'b0, idx} + (IDX_W+1)'(b);
        // Choose the source byte for output byte b, or zero past the lane top.
        always_comb begin
            if (sat || sel[IDX_W])
                lane_o[b*8 +: 8] = 8'h00;
            else
                lane_o[b*8 +: 8] = lane_i[sel[IDX_W-1:0]*8 +: 8];
        end
    end
endmodule

// File: rtl/lbs_mode_ctl.sv
// Module: lbs_mode_ctl
// Decodes the mode and length bit into the data source, the action on the
// upper lanes and the undefined-instruction flag.
// Assumes: inputs are qualified by the caller's valid.
module lbs_mode_ctl
    import lbs_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       len_i,
    output logic       undef_o,
    output logic       lo_from_dst_o,
    output hi_act_e    hi_act_o
);
    // Map each mode encoding to its source, upper-lane action and fault.
    always_comb begin
        undef_o       = 1'b0;
        lo_from_dst_o = 1'b0;
        hi_act_o      = HI_KEEP;
        unique case (mode_e'(mode_i))
            MODE_INPLACE: begin
                lo_from_dst_o = 1'b1;
                hi_act_o      = HI_KEEP;
            end
            MODE_NARROW: begin
                hi_act_o = HI_ZERO;
                undef_o  = len_i;
            end
            MODE_FULL:   hi_act_o = HI_SHIFT;
            MODE_RSVD:   undef_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_byte_rshift.sv
// Module: lane_byte_rshift (top)
// Lane-wise byte right shifter with one output register stage.
// Assumes: rst_n is synchronous and active low; request fields are valid
// only while in_vld_i is high.
module lane_byte_rshift
    import lbs_pkg::*;
#(
    parameter int LANE_BYTES = 16,
    parameter int LANES      = 2,
    parameter int CNT_W      = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld_i,
    input  logic [1:0]                      mode_i,
    input  logic                            len_i,
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic [LANE_BYTES*8*LANES-1:0]   src_i,
    input  logic [LANE_BYTES*8*LANES-1:0]   dst_i,
    output logic                            out_vld_o,
    output logic                            wr_en_o,
    output logic                            undef_o,
    output logic [LANE_BYTES*8*LANES-1:0]   res_o
);
    localparam int LANE_W = LANE_BYTES * 8;
    localparam int VEC_W  = LANE_W * LANES;

    logic              undef;
    logic              lo_from_dst;
    hi_act_e           hi_act;
    logic [VEC_W-1:0]  res_d;

    lbs_mode_ctl u_ctl (
        .mode_i        (mode_i),
        .len_i         (len_i),
        .undef_o       (undef),
        .lo_from_dst_o (lo_from_dst),
        .hi_act_o      (hi_act)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] l_src;
        logic [LANE_W-1:0] l_shf;

        assign l_src = lo_from_dst ? dst_i[g*LANE_W +: LANE_W] : src_i[g*LANE_W +: LANE_W];

        lbs_lane_shift #(
            .LANE_BYTES (LANE_BYTES),
            .CNT_W      (CNT_W)
        ) u_shf (
            .lane_i (l_src),
            .cnt_i  (cnt_i),
            .lane_o (l_shf)
        );

        // Select this lane's next result from fault, mode and shifter output.
        always_comb begin
            if (undef)
                res_d[g*LANE_W +: LANE_W] = dst_i[g*LANE_W +: LANE_W];
            else if (g == 0)
                res_d[g*LANE_W +: LANE_W] = l_shf;
            else begin
                unique case (hi_act)
                    HI_ZERO:  res_d[g*LANE_W +: LANE_W] = '0;
                    HI_SHIFT: res_d[g*LANE_W +: LANE_W] = l_shf;
                    default:  res_d[g*LANE_W +: LANE_W] = dst_i[g*LANE_W +: LANE_W];
                endcase
            end
        end
    end

    // Control outputs: valid, write request and fault, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            wr_en_o   <= 1'b0;
            undef_o   <= 1'b0;
        end else begin
            out_vld_o <= in_vld_i;
            wr_en_o   <= in_vld_i & ~undef;
            undef_o   <= in_vld_i & undef;
        end
    end

    // Result data register, loaded only for accepted requests.
    always_ff @(posedge clk) begin
        if (in_vld_i) res_o <= res_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld_o && !wr_en_o && !undef_o));

    // R2
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(in_vld_i));

    // R5
    inplace_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && $past(mode_i) == 2'b00)
        |-> res_o[VEC_W-1:LANE_W] == $past(dst_i[VEC_W-1:LANE_W]));

    // R6
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && $past(mode_i) == 2'b01 && !$past(len_i))
        |-> res_o[VEC_W-1:LANE_W] == '0);

    // R4
    full_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && $past(mode_i) == 2'b10 && $past(cnt_i) > CNT_W'(LANE_BYTES-1))
        |-> res_o == '0);

    // R9
    rsvd_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && $past(mode_i) == 2'b11) |-> undef_o);

    // R10
    undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (res_o == $past(dst_i) && !wr_en_o));
endmodule

// File: tb/lane_byte_rshift_tb.sv
module lane_byte_rshift_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_vld_i;
    logic [1:0]   mode_i;
    logic         len_i;
    logic [7:0]   cnt_i;
    logic [255:0] src_i;
    logic [255:0] dst_i;
    logic         out_vld_o;
    logic         wr_en_o;
    logic         undef_o;
    logic [255:0] res_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lane_byte_rshift u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i), .mode_i(mode_i),
        .len_i(len_i), .cnt_i(cnt_i), .src_i(src_i), .dst_i(dst_i),
        .out_vld_o(out_vld_o), .wr_en_o(wr_en_o), .undef_o(undef_o), .res_o(res_o)
    );

    function automatic logic [127:0] lane_exp(logic [127:0] v, int c);
        if (c > 15) return '0;
        return v >> (c * 8);
    endfunction

    task automatic check(string tag, logic [258:0] act, logic [258:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] m, logic l, int c, logic [255:0] s, logic [255:0] d);
        logic [255:0] e;
        logic         eu;
        string        tag;
        @(negedge clk);
        in_vld_i = 1'b1; mode_i = m; len_i = l; cnt_i = 8'(c); src_i = s; dst_i = d;
        eu = (m == 2'b11) || (m == 2'b01 && l);
        case (m)
            2'b00: begin e = {d[255:128], lane_exp(d[127:0], c)}; tag = "R5"; end
            2'b01: begin e = {128'h0, lane_exp(s[127:0], c)}; tag = l ? "R8" : "R6"; end
            2'b10: begin e = {lane_exp(s[255:128], c), lane_exp(s[127:0], c)}; tag = "R7"; end
            default: begin e = d; tag = "R9"; end
        endcase
        if (eu) begin e = d; tag = {tag, " R10"}; end
        else tag = {tag, (c > 15) ? " R4" : " R3", " R10 R2"};
        @(posedge clk);
        #1;
        check(tag, {out_vld_o, wr_en_o, undef_o, res_o}, {1'b1, ~eu, eu, e});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [255:0] s, d;
        rst_n = 1'b0; in_vld_i = 1'b0; mode_i = 2'b00; len_i = 1'b0;
        cnt_i = 8'h00; src_i = '0; dst_i = '0;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {3'b000, 256'h0}, {out_vld_o, wr_en_o, undef_o, 256'h0});
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R2: idle cycle gives no valid, write or fault
        check("R2", {3'b000, 256'h0}, {out_vld_o, wr_en_o, undef_o, 256'h0});
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 32; i++) begin
                case (p)
                    0: begin s[i*8 +: 8] = 8'(8'h80 + i); d[i*8 +: 8] = 8'(i + 1); end
                    1: begin s[i*8 +: 8] = 8'hFF; d[i*8 +: 8] = 8'h5A ^ 8'(i); end
                    default: begin s[i*8 +: 8] = 8'($urandom); d[i*8 +: 8] = 8'($urandom); end
                endcase
            end
            for (int m = 0; m < 4; m++)
                for (int l = 0; l < 2; l++)
                    for (int c = 0; c < 256; c++)
                        apply(2'(m), 1'(l), c, s, d);
        end
        @(negedge clk);
        in_vld_i = 1'b0;
        @(posedge clk);
        #1;
        // R2: output valid drops after an idle cycle
        check("R2", {3'b000, 256'h0}, {out_vld_o, wr_en_o, undef_o, 256'h0});
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule